// File: doc/BRIEF.md
# Non-destructive RAM Self-Test Controller

This block is a built-in self-test engine for a byte-wide synchronous SRAM. When it sees a start pulse it takes over the SRAM port. It first proves that each address line works, starting with the most significant line. It then sweeps every location in ascending order and tries ten data patterns on each one: all zeros, all ones, and a single one bit walked from bit 0 to bit 7. Before each read-back it writes the inverse of the test value to a neighbouring decoy location. A floating data bus that simply echoes the last value driven on it therefore reads back wrong and is caught.

The test preserves memory contents. Before a location is touched, its original byte and its decoy's byte are read and held, and both are written back once that location is finished, whether it failed or not. Each failing address goes into a 16-entry FIFO that a host drains through a valid/ready pair, so a run never stops at the first fault. At the end of the run the block pulses done, and it holds a pass flag, a sticky FIFO overflow flag and the highest address that passed every pattern.

Top module: `ram_bist_ctrl`

## Requirements
- R1: A synchronous reset, whether applied at rest or during a run, leaves busy, done, mem_we, mem_re, fail_valid and overflow low and the failure FIFO empty.
- R2: A start pulse while idle begins a run and raises busy until the run finishes. A start pulse while busy is ignored, so the run keeps the same length and the same results.
- R3: The address-line test runs first, for line k going from ADDR_W-1 down to 0. It writes 0x55 to address 0 and 0xAA to address 2^k, then reads both back. Any mismatch pushes 2^k into the FIFO, ahead of every cell failure.
- R4: Each location is tested in this order with 0x00, 0xFF, then 0x01, 0x02, ... 0x80. A location that misreads any pattern is pushed into the FIFO once.
- R5: After each test value is written to address A, its bitwise complement is written to decoy address A with bit 0 inverted, and only then is A read back. A location that returns the decoy value fails.
- R6: Every location the run writes, including decoys and the address-line test locations, ends the run holding its original value.
- R7: Failing addresses leave the FIFO in the order they were found, on fail_addr while fail_valid is high. An entry is popped on a clock edge where fail_valid and fail_ready are both high.
- R8: The FIFO holds 16 entries. Failures found while it is full are dropped and set a sticky overflow flag, which is cleared by the next accepted start.
- R9: done is a one-cycle pulse at the end of a run. pass is high after that pulse only if the address-line test and every cell passed.
- R10: top_good holds the highest address that passed all patterns.
- R11: mem_we and mem_re are never high in the same cycle. Read data is taken from mem_rdata one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run finishes |
| pass | output | 1 | Overall result of the last run |
| overflow | output | 1 | Sticky flag: failures were dropped because the FIFO was full |
| top_good | output | ADDR_W | Highest address that passed every pattern |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_re | output | 1 | SRAM read enable |
| mem_rdata | input | 8 | SRAM read data, valid one cycle after mem_re |
| fail_valid | output | 1 | A failing address is available |
| fail_ready | input | 1 | Host accepts the failing address |
| fail_addr | output | ADDR_W | Oldest failing address held |

## Verification
The bench runs the controller against a behavioural SRAM in five fault settings, each chosen to exercise a different checker.
- A clean memory sets the expected run length and shows that pass and top_good are reported and that contents survive.
- A single stuck-at-one bit shows that the zeros pattern catches the cell.
- An open address line, which aliases two halves of the memory, is caught only by the line test and yields that line's weight.
- A floating location that echoes the last bus value is caught only through the decoy write.
- A block of stuck-at-zero cells at the top overfills the FIFO and lowers top_good.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_PAT = DATA_W + 2;
  localparam logic [DATA_W-1:0] LINE_LO_VAL = 8'h55;
  localparam logic [DATA_W-1:0] LINE_HI_VAL = 8'hAA;

  typedef enum logic [4:0] {
    S_IDLE,
    S_AL_R0, S_AL_RK, S_AL_W0, S_AL_WK, S_AL_C0, S_AL_CK, S_AL_S0, S_AL_SK,
    S_CT_RA, S_CT_RD, S_CT_WA, S_CT_WD, S_CT_RB, S_CT_SA, S_CT_SD,
    S_FIN
  } bist_state_e;

  // Pattern order: zeros, ones, then one bit walking upward from bit 0.
  function automatic logic [DATA_W-1:0] pattern_of(input int unsigned idx);
    if (idx == 0) return '0;
    if (idx == 1) return '1;
    return DATA_W'(1) << (idx - 2);
  endfunction
endpackage

// File: rtl/bist_fifo.sv
module bist_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data,
  output logic         overflow
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [PW:0]  wp, rp;
  logic         full, empty;

  assign empty     = (wp == rp);
  assign full      = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign pop_valid = !empty;
  assign pop_data  = store[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) store[wp[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp       <= '0;
      rp       <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) begin
        if (full) overflow <= 1'b1;
        else      wp <= wp + (PW+1)'(1);
      end
      if (pop_valid && pop_ready) rp <= rp + (PW+1)'(1);
    end
  end
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] top_good,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic              flush
);
  localparam int LINE_W = $clog2(ADDR_W + 1);
  localparam int PIDX_W = $clog2(NUM_PAT);

  bist_state_e       st;
  logic [1:0]        rph;
  logic [LINE_W-1:0] line;
  logic [ADDR_W-1:0] cur;
  logic [PIDX_W-1:0] pidx;
  logic [DATA_W-1:0] sav_a, sav_b;
  logic              loc_bad, any_fail;

  logic [ADDR_W-1:0] line_addr, dec_addr, rd_addr_c, wr_addr_c;
  logic [DATA_W-1:0] pat, wr_data_c;
  logic              is_rd, is_wr, rd_last;

  assign line_addr = ADDR_W'(1) << line;
  assign dec_addr  = cur ^ ADDR_W'(1);
  assign pat       = pattern_of(32'(pidx));
  assign rd_last   = (rph == 2'd2);

  always_comb begin
    is_rd     = 1'b0;
    is_wr     = 1'b0;
    rd_addr_c = '0;
    wr_addr_c = '0;
    wr_data_c = '0;
    case (st)
      S_AL_R0, S_AL_C0: begin is_rd = 1'b1; rd_addr_c = '0;        end
      S_AL_RK, S_AL_CK: begin is_rd = 1'b1; rd_addr_c = line_addr; end
      S_CT_RA, S_CT_RB: begin is_rd = 1'b1; rd_addr_c = cur;       end
      S_CT_RD:          begin is_rd = 1'b1; rd_addr_c = dec_addr;  end
      S_AL_W0: begin is_wr = 1'b1; wr_addr_c = '0;        wr_data_c = LINE_LO_VAL; end
      S_AL_WK: begin is_wr = 1'b1; wr_addr_c = line_addr; wr_data_c = LINE_HI_VAL; end
      S_AL_S0: begin is_wr = 1'b1; wr_addr_c = '0;        wr_data_c = sav_a;       end
      S_AL_SK: begin is_wr = 1'b1; wr_addr_c = line_addr; wr_data_c = sav_b;       end
      S_CT_WA: begin is_wr = 1'b1; wr_addr_c = cur;       wr_data_c = pat;         end
      S_CT_WD: begin is_wr = 1'b1; wr_addr_c = dec_addr;  wr_data_c = ~pat;        end
      S_CT_SA: begin is_wr = 1'b1; wr_addr_c = cur;       wr_data_c = sav_a;       end
      S_CT_SD: begin is_wr = 1'b1; wr_addr_c = dec_addr;  wr_data_c = sav_b;       end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      rph       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      top_good  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      push      <= 1'b0;
      push_addr <= '0;
      flush     <= 1'b0;
      line      <= '0;
      cur       <= '0;
      pidx      <= '0;
      sav_a     <= '0;
      sav_b     <= '0;
      loc_bad   <= 1'b0;
      any_fail  <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      push   <= 1'b0;
      done   <= 1'b0;
      flush  <= 1'b0;

      // Reads take three phases: request, wait for the registered SRAM, capture.
      if (is_rd) begin
        if (rph == 2'd0) begin
          mem_re   <= 1'b1;
          mem_addr <= rd_addr_c;
        end
        rph <= rd_last ? 2'd0 : rph + 2'd1;
      end
      if (is_wr) begin
        mem_we    <= 1'b1;
        mem_addr  <= wr_addr_c;
        mem_wdata <= wr_data_c;
      end

      case (st)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          flush    <= 1'b1;
          any_fail <= 1'b0;
          loc_bad  <= 1'b0;
          pass     <= 1'b0;
          top_good <= '0;
          rph      <= '0;
          line     <= LINE_W'(ADDR_W - 1);
          st       <= S_AL_R0;
        end
        S_AL_R0: if (rd_last) begin sav_a <= mem_rdata; st <= S_AL_RK; end
        S_AL_RK: if (rd_last) begin sav_b <= mem_rdata; st <= S_AL_W0; end
        S_AL_W0: st <= S_AL_WK;
        S_AL_WK: st <= S_AL_C0;
        S_AL_C0: if (rd_last) begin
          if (mem_rdata != LINE_LO_VAL) loc_bad <= 1'b1;
          st <= S_AL_CK;
        end
        S_AL_CK: if (rd_last) begin
          if (mem_rdata != LINE_HI_VAL) loc_bad <= 1'b1;
          st <= S_AL_S0;
        end
        S_AL_S0: st <= S_AL_SK;
        S_AL_SK: begin
          if (loc_bad) begin
            push      <= 1'b1;
            push_addr <= line_addr;
            any_fail  <= 1'b1;
          end
          loc_bad <= 1'b0;
          if (line == '0) begin
            cur  <= '0;
            pidx <= '0;
            st   <= S_CT_RA;
          end else begin
            line <= line - LINE_W'(1);
            st   <= S_AL_R0;
          end
        end
        S_CT_RA: if (rd_last) begin sav_a <= mem_rdata; st <= S_CT_RD; end
        S_CT_RD: if (rd_last) begin sav_b <= mem_rdata; st <= S_CT_WA; end
        S_CT_WA: st <= S_CT_WD;
        S_CT_WD: st <= S_CT_RB;
        S_CT_RB: if (rd_last) begin
          if (mem_rdata != pat) loc_bad <= 1'b1;
          if (pidx == PIDX_W'(NUM_PAT - 1)) begin
            pidx <= '0;
            st   <= S_CT_SA;
          end else begin
            pidx <= pidx + PIDX_W'(1);
            st   <= S_CT_WA;
          end
        end
        S_CT_SA: st <= S_CT_SD;
        S_CT_SD: begin
          if (loc_bad) begin
            push      <= 1'b1;
            push_addr <= cur;
            any_fail  <= 1'b1;
          end else begin
            top_good <= cur;
          end
          loc_bad <= 1'b0;
          if (cur == '1) st <= S_FIN;
          else begin
            cur <= cur + ADDR_W'(1);
            st  <= S_CT_RA;
          end
        end
        S_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= !any_fail;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ram_bist_ctrl.sv
module ram_bist_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              overflow,
  output logic [ADDR_W-1:0] top_good,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              fail_valid,
  input  logic              fail_ready,
  output logic [ADDR_W-1:0] fail_addr
);
  logic              push, flush;
  logic [ADDR_W-1:0] push_addr;

  bist_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .pass(pass), .top_good(top_good),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata),
    .push(push), .push_addr(push_addr), .flush(flush)
  );

  bist_fifo #(.DEPTH(FIFO_DEPTH), .W(ADDR_W)) fifo_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push), .push_data(push_addr),
    .pop_valid(fail_valid), .pop_ready(fail_ready), .pop_data(fail_addr),
    .overflow(overflow)
  );
endmodule

// File: rtl/ram_bist_ctrl_chk.sv
module ram_bist_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              overflow,
  input logic              mem_we,
  input logic              mem_re,
  input logic              fail_valid,
  input logic              fail_ready,
  input logic [ADDR_W-1:0] fail_addr
);
  // R11
  we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));

  // R8
  ovf_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> !pass);

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_valid && !fail_ready && !busy && !start) |=> (fail_valid && $stable(fail_addr)));
endmodule

bind ram_bist_ctrl ram_bist_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pass(pass), .overflow(overflow), .mem_we(mem_we), .mem_re(mem_re),
  .fail_valid(fail_valid), .fail_ready(fail_ready), .fail_addr(fail_addr)
);

// File: tb/ram_bist_ctrl_tb_top.sv
`timescale 1ns/1ps
module ram_bist_ctrl_tb_top;
  localparam int AW = 8;
  localparam int MD = 1 << AW;

  // kind: 0 clean, 1 stuck-at-1 bit3 at faddr, 2 stuck-at-0 bit7 at all addr >= faddr,
  //       3 address bit faddr ignored (aliasing), 4 floating cell at faddr
  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] faddr;
    logic       epass;
    logic [7:0] etop;
    logic [4:0] ncnt;
    logic [7:0] efirst;
    logic       eovf;
  } scn_t;

  localparam scn_t SCN [5] = '{
    '{3'd0, 8'h00, 1'b1, 8'hFF, 5'd0,  8'h00, 1'b0},
    '{3'd1, 8'h25, 1'b0, 8'hFF, 5'd1,  8'h25, 1'b0},
    '{3'd3, 8'h20, 1'b0, 8'hFF, 5'd1,  8'h20, 1'b0},
    '{3'd4, 8'h43, 1'b0, 8'hFF, 5'd1,  8'h43, 1'b0},
    '{3'd2, 8'hE0, 1'b0, 8'hDF, 5'd16, 8'hE0, 1'b1}
  };
  string tag [5] = '{"R9", "R4", "R3", "R5", "R8"};

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, fail_ready = 1'b0;
  logic          busy, done, pass, overflow, mem_we, mem_re, fail_valid;
  logic [AW-1:0] top_good, mem_addr, fail_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  int errors = 0, checks = 0, cyc = 0, both_cnt = 0;
  logic [2:0] fk = '0;
  logic [7:0] fa = '0;
  logic [7:0] mem [MD];
  logic [7:0] snap [MD];
  logic [7:0] last_w = '0;

  always #5 clk = ~clk;

  ram_bist_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .overflow(overflow), .top_good(top_good), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .fail_valid(fail_valid), .fail_ready(fail_ready), .fail_addr(fail_addr)
  );

  function automatic logic [7:0] phys(input logic [7:0] a);
    return (fk == 3'd3) ? (a & ~fa) : a;
  endfunction

  function automatic logic [7:0] view(input logic [7:0] a);
    logic [7:0] v;
    v = mem[phys(a)];
    if (fk == 3'd1 && a == fa) v = v | 8'h08;
    if (fk == 3'd2 && a >= fa) v = v & 8'h7F;
    return v;
  endfunction

  // Behavioural SRAM: registered read, one cycle latency.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we && mem_re) both_cnt <= both_cnt + 1;
    if (mem_we) begin
      if (!(fk == 3'd4 && mem_addr == fa)) mem[phys(mem_addr)] <= mem_wdata;
      last_w <= mem_wdata;
    end
    if (mem_re) mem_rdata <= (fk == 3'd4 && mem_addr == fa) ? last_w : view(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < MD; i++) mem[i] = 8'((i * 37) + (seed * 11) + 5);
    for (int i = 0; i < MD; i++) snap[i] = view(8'(i));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Returns cycles from start to done; second start injected at restart_at if > 0.
  task automatic wait_done(output int n, input int restart_at);
    n = 0;
    while (!done && n < 40000) begin
      @(negedge clk); n++;
      if (n == restart_at) begin
        chk(busy == 1'b1, "R2", "busy mid-run", int'(busy), 1);
        start = 1'b1; @(negedge clk); start = 1'b0; n++;
      end
    end
  endtask

  task automatic drain(output int cnt, output int first, output int last);
    cnt = 0; first = -1; last = -1;
    fail_ready = 1'b1;
    while (fail_valid && cnt < 40) begin
      if (cnt == 0) first = int'(fail_addr);
      last = int'(fail_addr);
      cnt++;
      @(negedge clk);
    end
    fail_ready = 1'b0;
  endtask

  initial begin
    int n, clean_len, cnt, first, last, bad_keep;
    clean_len = 0;
    fill(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset
    chk(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    chk(!mem_we && !mem_re, "R1", "mem strobes after reset", int'({mem_we, mem_re}), 0);
    chk(!fail_valid && !overflow, "R1", "fifo after reset", int'({fail_valid, overflow}), 0);

    for (int s = 0; s < 5; s++) begin
      fk = SCN[s].kind; fa = SCN[s].faddr;
      fill(s + 1);
      pulse_start();
      wait_done(n, 0);
      if (s == 0) clean_len = n;
      chk(done == 1'b1, "R9", "done seen", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle", int'(done), 0);
      chk(pass == SCN[s].epass, tag[s], "pass flag", int'(pass), int'(SCN[s].epass));
      chk(top_good == SCN[s].etop, "R10", "top_good", int'(top_good), int'(SCN[s].etop));
      chk(overflow == SCN[s].eovf, "R8", "overflow", int'(overflow), int'(SCN[s].eovf));
      bad_keep = 0;
      for (int a = 0; a < MD; a++)
        if (!(fk == 3'd4 && a == int'(fa)) && view(8'(a)) !== snap[a]) bad_keep++;
      chk(bad_keep == 0, "R6", "locations altered", bad_keep, 0);
      drain(cnt, first, last);
      chk(cnt == int'(SCN[s].ncnt), "R7", "fifo entries", cnt, int'(SCN[s].ncnt));
      if (cnt > 0)
        chk(first == int'(SCN[s].efirst), tag[s], "first failing addr", first, int'(SCN[s].efirst));
      if (cnt > 1)
        chk(last == int'(SCN[s].efirst) + cnt - 1, "R8", "last kept addr", last, int'(SCN[s].efirst) + cnt - 1);
    end

    // R2: start pulse during a run is ignored
    fk = 3'd0; fa = 8'h00; fill(9);
    pulse_start();
    wait_done(n, 100);
    chk(n == clean_len, "R2", "run length with extra start", n, clean_len);
    @(negedge clk);
    chk(pass == 1'b1 && !fail_valid, "R2", "result with extra start", int'(pass), 1);

    // R1: reset in mid-run with FIFO holding entries
    fk = 3'd2; fa = 8'hE0; fill(10);
    pulse_start();
    n = 0;
    while (!fail_valid && n < 40000) begin @(negedge clk); n++; end
    chk(fail_valid == 1'b1 && busy == 1'b1, "R1", "fifo filled mid-run", int'({fail_valid, busy}), 3);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!busy && !fail_valid && !overflow, "R1", "state after mid-run reset",
        int'({busy, fail_valid, overflow}), 0);
    repeat (5) @(negedge clk);
    chk(!mem_we && !mem_re, "R1", "quiet after mid-run reset", int'({mem_we, mem_re}), 0);

    // R11
    chk(both_cnt == 0, "R11", "cycles with we and re both high", both_cnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule